// File: doc/BRIEF.md
# Delay-Line Bring-Up Sequencer

This block powers up a programmable sampling delay line ahead of a phase tuning sweep. A single-cycle start strobe launches a fixed sequence. Clock power-save gating is switched off first, so the clock keeps running while tuning. The delay line is then put into reset and power-down. A three-bit frequency band code, taken from the operating clock frequency in MHz, is loaded while the line is held in that state. Reset is released, then power-down, and finally the line and its clock output are enabled.

Each step takes exactly one clock cycle, so the order can be seen on the control word. After the last step the block samples the lock status of the delay line at a fixed interval. A lock seen at any sample gives a one-cycle done pulse. If no sample sees lock, a timeout error is raised instead. The control word, with its fields at fixed bit positions, drives the delay line's configuration register directly. A synchronous clear input aborts the sequence at any point.

Top module: `dline_bringup`

## Requirements
- R1: After reset the control word is all zero, `pwrsave_en` is 1, and `done` and `lock_timeout` are 0.
- R2: A start accepted in idle clears `pwrsave_en` exactly one cycle after the accepting edge. The control word is unchanged in that cycle. `pwrsave_en` then stays 0 after done and after a timeout.
- R3: The control-word steps follow strictly, one per cycle, starting on the second edge after the accepting edge. The order is: set reset (bit 30), set power-down (bit 29), load the band code, clear reset, clear power-down, set line enable (bit 16), set clock-output enable (bit 18).
- R4: The band code sits in bits 26:24. Its value is the smallest n whose upper bound, from the list 112, 125, 137, 150, 162, 175, 187, 200 MHz for n = 0..7, is at least the frequency. A frequency above 200 MHz gives code 0.
- R5: The band field changes only in a cycle in which reset and power-down are both set, except when cleared by `soft_clr`.
- R6: Lock is sampled on the edge right after the clock-output enable step, and then every POLL_INTERVAL cycles. A sample that sees lock makes `done` 1 for exactly one cycle after that edge.
- R7: After POLL_LIMIT samples without lock, `lock_timeout` goes to 1 on the edge of the last sample and `done` stays 0. `lock_timeout` holds until the next accepted start or a clear.
- R8: A start strobe while the sequence is running has no effect on the control word or its timing.
- R9: `soft_clr` returns the block to idle on the next edge. The control word is cleared, `pwrsave_en` goes back to 1, and `done` and `lock_timeout` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_clr | input | 1 | Synchronous abort back to idle |
| start | input | 1 | Start strobe, taken only when idle |
| freq_mhz | input | FREQ_W | Operating clock frequency in MHz |
| lock_in | input | 1 | Lock status of the delay line |
| ctl_word | output | 32 | Delay-line control register value |
| pwrsave_en | output | 1 | Clock power-save gating enable |
| done | output | 1 | One-cycle pulse when lock is seen |
| lock_timeout | output | 1 | Lock never seen within the poll budget |

## Verification
The edge on which start is accepted is counted as edge 0. Power-save clears after edge 1, and the seven control steps appear after edges 2 to 8, one per edge. Lock samples fall on edges 9 + k·POLL_INTERVAL. The bench drives every input on a falling edge and counts falling edges from the accepting edge. It reads each result at the falling edge after the rising edge on which that result is due. It also checks the cycle before and the cycle after each lock or timeout edge, so an early or late response shows up as a mismatch.

// File: rtl/dlb_pkg.sv
package dlb_pkg;

  localparam int unsigned CW_W       = 32;
  localparam int unsigned BIT_RST    = 30;
  localparam int unsigned BIT_PDN    = 29;
  localparam int unsigned BIT_CKO    = 18;
  localparam int unsigned BIT_EN     = 16;
  localparam int unsigned BAND_LSB   = 24;
  localparam int unsigned BAND_W     = 3;
  localparam int unsigned BAND_N     = 1 << BAND_W;

  localparam int unsigned BAND_TOP [BAND_N] = '{112, 125, 137, 150, 162, 175, 187, 200};

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PS_OFF,
    ST_SET_RST,
    ST_SET_PDN,
    ST_LOAD_BAND,
    ST_CLR_RST,
    ST_CLR_PDN,
    ST_SET_EN,
    ST_SET_CKO,
    ST_WAIT_LOCK
  } seq_state_t;

endpackage

// File: rtl/dlb_rst_sync.sv
module dlb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dlb_band_map.sv
module dlb_band_map
  import dlb_pkg::*;
#(
  parameter int unsigned FREQ_W = 9
) (
  input  logic [FREQ_W-1:0] freq_mhz,
  output logic [BAND_W-1:0] band_code
);

  logic [BAND_N-1:0] above;

  for (genvar i = 0; i < BAND_N; i++) begin : g_cmp
    assign above[i] = (freq_mhz > FREQ_W'(BAND_TOP[i]));
  end

  // Code counts bounds exceeded; beyond the top bound the code falls back to 0.
  always_comb begin
    if (above[BAND_N-1]) begin
      band_code = '0;
    end else begin
      band_code = BAND_W'($countones(above[BAND_N-2:0]));
    end
  end

endmodule

// File: rtl/dlb_poll_timer.sv
module dlb_poll_timer #(
  parameter int unsigned POLL_INTERVAL = 50,
  parameter int unsigned POLL_LIMIT    = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sample_tick,
  output logic last_sample
);

  localparam int unsigned IV_W = (POLL_INTERVAL > 1) ? $clog2(POLL_INTERVAL) : 1;
  localparam int unsigned SC_W = $clog2(POLL_LIMIT + 1);

  logic [IV_W-1:0] iv_q, iv_d;
  logic [SC_W-1:0] sc_q, sc_d;
  logic            cnt_en;

  assign sample_tick = run && (iv_q == '0);
  assign last_sample = sample_tick && (sc_q == SC_W'(POLL_LIMIT - 1));
  assign cnt_en      = 1'b1;

  always_comb begin
    iv_d = iv_q;
    sc_d = sc_q;
    if (!run) begin
      iv_d = '0;
      sc_d = '0;
    end else if (sample_tick) begin
      iv_d = IV_W'(POLL_INTERVAL - 1);
      sc_d = sc_q + 1'b1;
    end else begin
      iv_d = iv_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q <= '0;
      sc_q <= '0;
    end else if (cnt_en) begin
      iv_q <= iv_d;
      sc_q <= sc_d;
    end
  end

endmodule

// File: rtl/dlb_seq_fsm.sv
module dlb_seq_fsm
  import dlb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr,
  input  logic       start,
  input  logic       lock_in,
  input  logic       sample_tick,
  input  logic       last_sample,
  output seq_state_t state,
  output logic       accept,
  output logic       lock_ok,
  output logic       lock_fail
);

  seq_state_t state_q, state_d;

  assign state     = state_q;
  assign accept    = (state_q == ST_IDLE) && start && !soft_clr;
  assign lock_ok   = (state_q == ST_WAIT_LOCK) && sample_tick && lock_in && !soft_clr;
  assign lock_fail = (state_q == ST_WAIT_LOCK) && last_sample && !lock_in && !soft_clr;

  always_comb begin
    state_d = state_q;
    if (soft_clr) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:      if (start) state_d = ST_PS_OFF;
        ST_PS_OFF:    state_d = ST_SET_RST;
        ST_SET_RST:   state_d = ST_SET_PDN;
        ST_SET_PDN:   state_d = ST_LOAD_BAND;
        ST_LOAD_BAND: state_d = ST_CLR_RST;
        ST_CLR_RST:   state_d = ST_CLR_PDN;
        ST_CLR_PDN:   state_d = ST_SET_EN;
        ST_SET_EN:    state_d = ST_SET_CKO;
        ST_SET_CKO:   state_d = ST_WAIT_LOCK;
        ST_WAIT_LOCK: if (lock_ok || lock_fail) state_d = ST_IDLE;
        default:      state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/dline_bringup.sv
module dline_bringup
  import dlb_pkg::*;
#(
  parameter int unsigned FREQ_W        = 9,
  parameter int unsigned POLL_INTERVAL = 50,
  parameter int unsigned POLL_LIMIT    = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              start,
  input  logic [FREQ_W-1:0] freq_mhz,
  input  logic              lock_in,
  output logic [31:0]       ctl_word,
  output logic              pwrsave_en,
  output logic              done,
  output logic              lock_timeout
);

  logic              rst_int_n;
  seq_state_t        state;
  logic              accept, lock_ok, lock_fail;
  logic              sample_tick, last_sample;
  logic [BAND_W-1:0] band_next;

  logic              rst_q, pdn_q, en_q, cko_q, ps_q, done_q, tmo_q;
  logic [BAND_W-1:0] band_q;

  // Per-field clock enables and next values
  logic              rst_ce, pdn_ce, en_ce, cko_ce, band_ce, ps_ce, tmo_ce;
  logic              rst_d, pdn_d, en_d, cko_d, ps_d, tmo_d;
  logic [BAND_W-1:0] band_d;

  dlb_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dlb_band_map #(.FREQ_W(FREQ_W)) u_band_map (
    .freq_mhz  (freq_mhz),
    .band_code (band_next)
  );

  dlb_poll_timer #(
    .POLL_INTERVAL (POLL_INTERVAL),
    .POLL_LIMIT    (POLL_LIMIT)
  ) u_poll (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .run         (state == ST_WAIT_LOCK),
    .sample_tick (sample_tick),
    .last_sample (last_sample)
  );

  dlb_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .soft_clr    (soft_clr),
    .start       (start),
    .lock_in     (lock_in),
    .sample_tick (sample_tick),
    .last_sample (last_sample),
    .state       (state),
    .accept      (accept),
    .lock_ok     (lock_ok),
    .lock_fail   (lock_fail)
  );

  always_comb begin
    rst_ce  = soft_clr || (state == ST_SET_RST) || (state == ST_CLR_RST);
    rst_d   = !soft_clr && (state == ST_SET_RST);
    pdn_ce  = soft_clr || (state == ST_SET_PDN) || (state == ST_CLR_PDN);
    pdn_d   = !soft_clr && (state == ST_SET_PDN);
    band_ce = soft_clr || (state == ST_LOAD_BAND);
    band_d  = soft_clr ? '0 : band_next;
    en_ce   = soft_clr || (state == ST_SET_EN);
    en_d    = !soft_clr;
    cko_ce  = soft_clr || (state == ST_SET_CKO);
    cko_d   = !soft_clr;
    ps_ce   = soft_clr || (state == ST_PS_OFF);
    ps_d    = soft_clr;
    tmo_ce  = soft_clr || accept || lock_fail;
    tmo_d   = !soft_clr && lock_fail;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rst_q  <= 1'b0;
      pdn_q  <= 1'b0;
      band_q <= '0;
      en_q   <= 1'b0;
      cko_q  <= 1'b0;
      ps_q   <= 1'b1;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      if (rst_ce)  rst_q  <= rst_d;
      if (pdn_ce)  pdn_q  <= pdn_d;
      if (band_ce) band_q <= band_d;
      if (en_ce)   en_q   <= en_d;
      if (cko_ce)  cko_q  <= cko_d;
      if (ps_ce)   ps_q   <= ps_d;
      if (tmo_ce)  tmo_q  <= tmo_d;
      done_q <= lock_ok;
    end
  end

  always_comb begin
    ctl_word                                = '0;
    ctl_word[BIT_RST]                       = rst_q;
    ctl_word[BIT_PDN]                       = pdn_q;
    ctl_word[BAND_LSB +: BAND_W]            = band_q;
    ctl_word[BIT_EN]                        = en_q;
    ctl_word[BIT_CKO]                       = cko_q;
  end

  assign pwrsave_en   = ps_q;
  assign done         = done_q;
  assign lock_timeout = tmo_q;

endmodule

// File: rtl/dlb_checker.sv
module dlb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_clr,
  input logic [31:0] ctl_word,
  input logic        pwrsave_en,
  input logic        done,
  input logic        lock_timeout
);

  logic       c_rst, c_pdn, c_en, c_cko;
  logic [2:0] c_band;

  assign c_rst  = ctl_word[30];
  assign c_pdn  = ctl_word[29];
  assign c_en   = ctl_word[16];
  assign c_cko  = ctl_word[18];
  assign c_band = ctl_word[26:24];

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_band_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(c_band) && !$past(soft_clr)) |-> (c_rst && c_pdn));

  assert_en_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(c_en) && !$past(soft_clr)) |-> (!c_rst && !c_pdn));

  assert_cko_after_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_cko) |-> $past(c_en));

  assert_ps_off_when_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word != 32'd0) |-> !pwrsave_en);

  assert_exclusive_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && lock_timeout));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_clr) |-> (ctl_word == 32'd0 && pwrsave_en && !done && !lock_timeout));

endmodule

bind dline_bringup dlb_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_clr     (soft_clr),
  .ctl_word     (ctl_word),
  .pwrsave_en   (pwrsave_en),
  .done         (done),
  .lock_timeout (lock_timeout)
);

// File: tb/dline_bringup_tb.sv
module dline_bringup_tb;

  localparam int FREQ_W = 9;
  localparam int PIV    = 50;
  localparam int PLIM   = 50;
  localparam int FIRST_SAMPLE = 9;
  localparam int LAST_SAMPLE  = FIRST_SAMPLE + (PLIM - 1) * PIV;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              soft_clr;
  logic              start;
  logic [FREQ_W-1:0] freq_mhz;
  logic              lock_in;
  logic [31:0]       ctl_word;
  logic              pwrsave_en;
  logic              done;
  logic              lock_timeout;

  int n_checks = 0;
  int n_fail   = 0;
  int edge_no  = 0;

  always #10 clk = ~clk;

  dline_bringup #(
    .FREQ_W(FREQ_W), .POLL_INTERVAL(PIV), .POLL_LIMIT(PLIM)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .start(start),
    .freq_mhz(freq_mhz), .lock_in(lock_in), .ctl_word(ctl_word),
    .pwrsave_en(pwrsave_en), .done(done), .lock_timeout(lock_timeout)
  );

  function automatic logic [31:0] cw(input bit r, input bit p, input int b, input bit e, input bit c);
    logic [31:0] v;
    v = '0;
    v[30] = r; v[29] = p; v[26:24] = 3'(b); v[16] = e; v[18] = c;
    return v;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at edge %0d: actual=%h expected=%h", req, what, edge_no, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    edge_no++;
  endtask

  task automatic step_to(input int e);
    while (edge_no < e) step();
  endtask

  // After return: edge 0 (accepting edge) has passed
  task automatic launch(input int f);
    @(negedge clk);
    freq_mhz = FREQ_W'(f);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edge_no = 0;
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "ctl_word", ctl_word, 32'd0);
    check("R1", "pwrsave_en", {31'd0, pwrsave_en}, 32'd1);
    check("R1", "done", {31'd0, done}, 32'd0);
    check("R1", "lock_timeout", {31'd0, lock_timeout}, 32'd0);
  endtask

  task automatic t_order_and_quick_lock();
    lock_in = 1'b1;
    launch(150);
    check("R2", "pwrsave at e0", {31'd0, pwrsave_en}, 32'd1);
    step();
    check("R2", "pwrsave at e1", {31'd0, pwrsave_en}, 32'd0);
    check("R2", "ctl at e1", ctl_word, 32'd0);
    step(); check("R3", "set reset", ctl_word, cw(1, 0, 0, 0, 0));
    step(); check("R3", "set pdn",   ctl_word, cw(1, 1, 0, 0, 0));
    step(); check("R3", "band",      ctl_word, cw(1, 1, 3, 0, 0));
    step(); check("R3", "clr reset", ctl_word, cw(0, 1, 3, 0, 0));
    step(); check("R3", "clr pdn",   ctl_word, cw(0, 0, 3, 0, 0));
    step(); check("R3", "set en",    ctl_word, cw(0, 0, 3, 1, 0));
    step(); check("R3", "set cko",   ctl_word, cw(0, 0, 3, 1, 1));
    check("R6", "done before sample", {31'd0, done}, 32'd0);
    step(); check("R6", "done at first sample", {31'd0, done}, 32'd1);
    step(); check("R6", "done one cycle", {31'd0, done}, 32'd0);
    check("R2", "pwrsave after done", {31'd0, pwrsave_en}, 32'd0);
    check("R7", "no timeout on lock", {31'd0, lock_timeout}, 32'd0);
    clear_pulse();
  endtask

  task automatic t_band(input int f, input int code);
    lock_in = 1'b0;
    launch(f);
    step_to(4);
    check("R4", $sformatf("band for %0d MHz", f), ctl_word, cw(1, 1, code, 0, 0));
    clear_pulse();
  endtask

  task automatic t_second_sample_lock();
    lock_in = 1'b0;
    launch(180);
    step_to(FIRST_SAMPLE);
    check("R6", "no done without lock", {31'd0, done}, 32'd0);
    lock_in = 1'b1;
    step_to(FIRST_SAMPLE + PIV - 1);
    check("R6", "done not before second sample", {31'd0, done}, 32'd0);
    step();
    check("R6", "done at second sample", {31'd0, done}, 32'd1);
    clear_pulse();
  endtask

  task automatic t_last_sample_lock();
    lock_in = 1'b0;
    launch(120);
    step_to(LAST_SAMPLE - 1);
    lock_in = 1'b1;
    step();
    check("R6", "done at last sample", {31'd0, done}, 32'd1);
    check("R7", "no timeout at last-sample lock", {31'd0, lock_timeout}, 32'd0);
    clear_pulse();
  endtask

  task automatic t_timeout();
    lock_in = 1'b0;
    launch(200);
    step_to(LAST_SAMPLE - 1);
    check("R7", "timeout early", {31'd0, lock_timeout}, 32'd0);
    step();
    check("R7", "timeout flag", {31'd0, lock_timeout}, 32'd1);
    check("R7", "no done on timeout", {31'd0, done}, 32'd0);
    step_to(LAST_SAMPLE + 5);
    check("R7", "timeout held", {31'd0, lock_timeout}, 32'd1);
    check("R2", "pwrsave after timeout", {31'd0, pwrsave_en}, 32'd0);
    launch(200);
    check("R7", "timeout cleared by start", {31'd0, lock_timeout}, 32'd0);
    clear_pulse();
  endtask

  task automatic t_start_while_busy();
    lock_in = 1'b1;
    launch(130);
    step_to(2);
    start = 1'b1;
    step();
    start = 1'b0;
    check("R8", "ctl after busy start", ctl_word, cw(1, 1, 0, 0, 0));
    step_to(FIRST_SAMPLE);
    check("R8", "done timing unchanged", {31'd0, done}, 32'd1);
    step_to(FIRST_SAMPLE + 12);
    check("R8", "no restart from busy start", ctl_word, cw(0, 0, 2, 1, 1));
    clear_pulse();
  endtask

  task automatic t_clear_mid();
    lock_in = 1'b1;
    launch(160);
    step_to(5);
    soft_clr = 1'b1;
    step();
    soft_clr = 1'b0;
    check("R9", "ctl cleared", ctl_word, 32'd0);
    check("R9", "pwrsave restored", {31'd0, pwrsave_en}, 32'd1);
    step_to(FIRST_SAMPLE + 2);
    check("R9", "stays idle", ctl_word, 32'd0);
    check("R9", "no done after clear", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(200_000 * 20);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; soft_clr = 1'b0; start = 1'b0; freq_mhz = '0; lock_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_order_and_quick_lock();
    t_band(50, 0);   t_band(112, 0);  t_band(113, 1);  t_band(125, 1);
    t_band(126, 2);  t_band(137, 2);  t_band(151, 4);  t_band(175, 5);
    t_band(187, 6);  t_band(188, 7);  t_band(200, 7);  t_band(201, 0);
    t_band(400, 0);
    t_second_sample_lock();
    t_last_sample_lock();
    t_timeout();
    t_start_while_busy();
    t_clear_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule